// File: doc/BRIEF.md
# Link Test Word Source and Checker

This block sits on the parallel side of a chained serial link and is used while the link is brought up and while its bit-error rate is measured. On the transmit side it picks the 16-bit word that is handed to the serializer each cycle. The choice is set by a 4-bit source code: zero, a word from neighbouring logic, a word held in a configuration register, the fixed alignment word 0x00FF, the word just received (loopback), or a pseudo-random sequence.

On the receive side it watches the deserialized words. It keeps the most recent raw word and the most recent word that was not zero. It counts non-zero words and checks a pseudo-random stream against its own copy of the generator. It also runs an alignment detector that reports when the far end is sending the alignment word steadily. Counter widths, the alignment run length and the generator seed are parameters.

Top module: `link_test_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is zero after that edge: `tx_word`, `rx_raw`, `rx_last_nz`, `train_ok`, `err_count` and `data_count`.
- R2: When `tx_en` is low at an edge, `tx_word` is 0x0000 after that edge, whatever `tx_sel` holds.
- R3: When `tx_en` is high, `tx_word` after the edge follows `tx_sel` sampled at that edge. Code 0 gives 0x0000, code 1 gives `user_word`, code 2 gives `custom_word`, and code 3 gives 0x00FF. Codes 6 to 15 give 0x0000.
- R4: With `tx_en` high and code 4, `tx_word` after the edge equals `rx_word` sampled at that edge. This holds whether or not `rx_en` is set.
- R5: With `tx_en` high and code 5, `tx_word` carries a pseudo-random sequence. The generator state starts at 0xACE1 after reset, is emitted as it stands, and then advances to {s[14:0], s[15]^s[13]^s[12]^s[10]}. The state advances only on cycles in which it is emitted.
- R6: At an edge where `rx_en` is high, `rx_raw` takes `rx_word`; otherwise it holds. `rx_last_nz` takes `rx_word` only at edges where `rx_en` is high and `rx_word` is non-zero.
- R7: `data_count` rises by one for each edge with `rx_en` high and `rx_word` non-zero. Zero words and cycles with `rx_en` low leave it unchanged.
- R8: The checker runs while `rx_en` is high and `tx_sel` is 5. The first non-zero word seeds the expected value, which is the generator successor of that word. Each later non-zero word is compared with the expected value, and a mismatch adds one to `err_count`. After each comparison the expected value steps to its own successor. Zero words are skipped. Leaving code 5, or lowering `rx_en`, discards the seed, so the next non-zero word reseeds the checker.
- R9: `cnt_clr` high at an edge zeroes both counters and discards the checker seed, taking priority over any count at the same edge.
- R10: Both counters stop at all ones (2^CNT_W - 1) and do not wrap.
- R11: While `train_en` is high, `train_ok` rises after TRAIN_LEN (default 16) consecutive enabled received words equal to 0x00FF. An enabled word that is not 0x00FF restarts the run but does not drop a flag already set. Cycles with `rx_en` low neither extend nor break the run. `train_ok` is low after any edge with `train_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_sel | input | 4 | Transmit source code |
| user_word | input | 16 | Word from neighbouring logic (code 1) |
| custom_word | input | 16 | Configured word (code 2) |
| train_en | input | 1 | Alignment detection enable |
| cnt_clr | input | 1 | Clear both counters |
| rx_word | input | 16 | Deserialized received word |
| tx_word | output | 16 | Word to the serializer |
| rx_raw | output | 16 | Last received word |
| rx_last_nz | output | 16 | Last non-zero received word |
| train_ok | output | 1 | Alignment achieved |
| err_count | output | CNT_W | Pseudo-random mismatch count |
| data_count | output | CNT_W | Non-zero word count |

## Verification
The source selector is driven with every defined code, with unused codes and with the transmitter disabled, using distinct user, custom and received words so that a swapped input shows up as a wrong value. A received pseudo-random stream with one flipped word and an inserted zero word shows that one corruption costs exactly one error and that zero words are neither counted nor checked. Alignment runs of fifteen words, a broken run and a full run separate an off-by-one in the run length from a missing restart. A narrow-counter instance is pushed past all ones to expose wrapping.

// File: rtl/link_test_pkg.sv
// Shared definitions for the link test engine: source codes, the
// alignment word and the pseudo-random generator step.
package link_test_pkg;

    typedef enum logic [3:0] {
        SRC_ZERO   = 4'd0,
        SRC_USER   = 4'd1,
        SRC_CUSTOM = 4'd2,
        SRC_TRAIN  = 4'd3,
        SRC_LOOP   = 4'd4,
        SRC_PRBS   = 4'd5
    } src_sel_e;

    localparam int          WORD_W     = 16;
    localparam logic [15:0] TRAIN_WORD = 16'h00FF;

    // One step of the 16-bit maximal-length generator (taps 16,14,13,11).
    function automatic logic [15:0] prbs_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/link_tx_source.sv
// Transmit word selector. Registers one word per cycle picked by the
// source code. Assumes tx_sel is held stable by its owner; unused codes
// and a disabled transmitter both send zero.
module link_tx_source
    import link_test_pkg::*;
#(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [3:0]        tx_sel,
    input  logic [WORD_W-1:0] user_word,
    input  logic [WORD_W-1:0] custom_word,
    input  logic [WORD_W-1:0] rx_word,
    output logic [WORD_W-1:0] tx_word
);

    logic [WORD_W-1:0] gen_q;
    logic [WORD_W-1:0] pick;
    logic              gen_use;

    // Choose the next outgoing word from the source code.
    always_comb begin
        gen_use = tx_en && (tx_sel == SRC_PRBS);
        unique case (tx_sel)
            SRC_USER:   pick = user_word;
            SRC_CUSTOM: pick = custom_word;
            SRC_TRAIN:  pick = TRAIN_WORD;
            SRC_LOOP:   pick = rx_word;
            SRC_PRBS:   pick = gen_q;
            default:    pick = '0;
        endcase
        if (!tx_en) pick = '0;
    end

    // Register the outgoing word and step the generator when it is used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word <= '0;
            gen_q   <= SEED;
        end else begin
            tx_word <= pick;
            if (gen_use) gen_q <= prbs_step(gen_q);
        end
    end

    AST_TX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en) |=> (tx_word == '0)); // R2
    AST_TX_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_sel == SRC_TRAIN) |=> (tx_word == TRAIN_WORD)); // R3
    AST_TX_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_sel == SRC_LOOP) |=> (tx_word == $past(rx_word))); // R4

endmodule

// File: rtl/link_rx_checker.sv
// Receive monitor: holds the last raw and last non-zero word, counts
// non-zero words and checks a pseudo-random stream. Assumes the far end
// runs the same generator; the first non-zero word seeds the local copy.
module link_rx_checker
    import link_test_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              chk_mode,
    input  logic              cnt_clr,
    input  logic [WORD_W-1:0] rx_word,
    output logic [WORD_W-1:0] rx_raw,
    output logic [WORD_W-1:0] rx_last_nz,
    output logic [CNT_W-1:0]  err_count,
    output logic [CNT_W-1:0]  data_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic              take;
    logic              chk_on;
    logic              synced_q;
    logic [WORD_W-1:0] expect_q;

    assign take   = rx_en && (rx_word != '0);
    assign chk_on = rx_en && chk_mode;

    // Capture the raw word and the last non-zero word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_raw     <= '0;
            rx_last_nz <= '0;
        end else begin
            if (rx_en) rx_raw     <= rx_word;
            if (take)  rx_last_nz <= rx_word;
        end
    end

    // Count non-zero words, track the expected sequence and count mismatches.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr) begin
            data_count <= '0;
            err_count  <= '0;
            synced_q   <= 1'b0;
            expect_q   <= '0;
        end else begin
            if (take && data_count != CNT_MAX) data_count <= data_count + 1'b1;
            if (!chk_on) begin
                synced_q <= 1'b0;
            end else if (take) begin
                if (!synced_q) begin
                    synced_q <= 1'b1;
                    expect_q <= prbs_step(rx_word);
                end else begin
                    expect_q <= prbs_step(expect_q);
                    if (rx_word != expect_q && err_count != CNT_MAX)
                        err_count <= err_count + 1'b1;
                end
            end
        end
    end

    AST_NZ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (rx_last_nz == $past(rx_word))); // R6
    AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !cnt_clr) |=> $stable(data_count)); // R7
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_on && !cnt_clr) |=> $stable(err_count)); // R8
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (data_count == '0 && err_count == '0)); // R9
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_count == CNT_MAX && !cnt_clr) |=> (data_count == CNT_MAX)); // R10

endmodule

// File: rtl/link_align_detect.sv
// Alignment detector: raises its flag after a run of consecutive
// alignment words. Assumes disabled receive cycles are gaps, not breaks.
module link_align_detect
    import link_test_pkg::*;
#(
    parameter int TRAIN_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train_en,
    input  logic              rx_en,
    input  logic [WORD_W-1:0] rx_word,
    output logic              train_ok
);

    localparam int            RUN_W    = $clog2(TRAIN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(TRAIN_LEN);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(TRAIN_LEN - 1);

    logic [RUN_W-1:0] run_q;

    // Track the run of alignment words and latch success.
    always_ff @(posedge clk) begin
        if (!rst_n || !train_en) begin
            run_q    <= '0;
            train_ok <= 1'b0;
        end else if (rx_en) begin
            if (rx_word == TRAIN_WORD) begin
                if (run_q != RUN_FULL) run_q <= run_q + 1'b1;
                if (run_q == RUN_LAST) train_ok <= 1'b1;
            end else begin
                run_q <= '0;
            end
        end
    end

    AST_TRAIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!train_en) |=> (!train_ok)); // R11
    AST_TRAIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (train_en && train_ok) |=> train_ok); // R11

endmodule

// File: rtl/link_test_engine.sv
// Link test engine top: transmit source selector, receive checker and
// alignment detector on a 16-bit parallel word path.
module link_test_engine
    import link_test_pkg::*;
#(
    parameter int          CNT_W     = 32,
    parameter int          TRAIN_LEN = 16,
    parameter logic [15:0] SEED      = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic [3:0]       tx_sel,
    input  logic [15:0]      user_word,
    input  logic [15:0]      custom_word,
    input  logic             train_en,
    input  logic             cnt_clr,
    input  logic [15:0]      rx_word,
    output logic [15:0]      tx_word,
    output logic [15:0]      rx_raw,
    output logic [15:0]      rx_last_nz,
    output logic             train_ok,
    output logic [CNT_W-1:0] err_count,
    output logic [CNT_W-1:0] data_count
);

    logic chk_mode;
    assign chk_mode = (tx_sel == SRC_PRBS);

    link_tx_source #(.SEED(SEED)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_sel(tx_sel),
        .user_word(user_word), .custom_word(custom_word),
        .rx_word(rx_word), .tx_word(tx_word)
    );

    link_rx_checker #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .chk_mode(chk_mode),
        .cnt_clr(cnt_clr), .rx_word(rx_word), .rx_raw(rx_raw),
        .rx_last_nz(rx_last_nz), .err_count(err_count),
        .data_count(data_count)
    );

    link_align_detect #(.TRAIN_LEN(TRAIN_LEN)) u_align (
        .clk(clk), .rst_n(rst_n), .train_en(train_en), .rx_en(rx_en),
        .rx_word(rx_word), .train_ok(train_ok)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        (!rst_n) |=> (tx_word == '0 && data_count == '0 && !train_ok)); // R1

endmodule

// File: tb/link_test_engine_tb.sv
// Self-checking bench: source vector table, then directed tests.
module link_test_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, rx_en = 1'b0, train_en = 1'b0, cnt_clr = 1'b0;
    logic [3:0]  tx_sel = 4'd0;
    logic [15:0] user_word = '0, custom_word = '0, rx_word = '0;
    logic [15:0] tx_word, rx_raw, rx_last_nz, s_tx, s_raw, s_nz;
    logic        train_ok, s_ok;
    logic [31:0] err_count, data_count;
    logic [3:0]  s_err, s_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    link_test_engine u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .tx_sel(tx_sel),
        .user_word(user_word), .custom_word(custom_word), .train_en(train_en),
        .cnt_clr(cnt_clr), .rx_word(rx_word), .tx_word(tx_word), .rx_raw(rx_raw),
        .rx_last_nz(rx_last_nz), .train_ok(train_ok), .err_count(err_count),
        .data_count(data_count)
    );

    link_test_engine #(.CNT_W(4)) u_sat (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .tx_sel(tx_sel),
        .user_word(user_word), .custom_word(custom_word), .train_en(train_en),
        .cnt_clr(cnt_clr), .rx_word(rx_word), .tx_word(s_tx), .rx_raw(s_raw),
        .rx_last_nz(s_nz), .train_ok(s_ok), .err_count(s_err),
        .data_count(s_data)
    );

    // Source vectors: code, user, custom, received, expected tx word (R3, R4).
    localparam int NV = 9;
    localparam logic [3:0]  V_SEL [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd15, 4'd1, 4'd4};
    localparam logic [15:0] V_USR [NV] = '{16'h1234, 16'h1234, 16'h1234, 16'h1234, 16'h1234, 16'h1234, 16'h1234, 16'hFFFF, 16'h0001};
    localparam logic [15:0] V_CUS [NV] = '{16'h5678, 16'h5678, 16'h5678, 16'h5678, 16'h5678, 16'h5678, 16'h5678, 16'h5678, 16'h0002};
    localparam logic [15:0] V_RX  [NV] = '{16'h9ABC, 16'h9ABC, 16'h9ABC, 16'h9ABC, 16'h9ABC, 16'h9ABC, 16'h9ABC, 16'h9ABC, 16'hC3C3};
    localparam logic [15:0] V_EXP [NV] = '{16'h0000, 16'h1234, 16'h5678, 16'h00FF, 16'h9ABC, 16'h0000, 16'h0000, 16'hFFFF, 16'hC3C3};

    function automatic logic [15:0] nx(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] w;
        int          e_err;
        // R1: reset state with inputs busy.
        tx_en = 1; rx_en = 1; tx_sel = 4'd1; user_word = 16'hBEEF; rx_word = 16'h1111;
        step(); step();
        chk("R1 tx_word", tx_word, 0);
        chk("R1 rx_raw", rx_raw, 0);
        chk("R1 rx_last_nz", rx_last_nz, 0);
        chk("R1 data_count", data_count, 0);
        chk("R1 err_count", err_count, 0);
        chk("R1 train_ok", train_ok, 0);
        rx_en = 0; rst_n = 1;

        // R5: generator sequence from the seed.
        tx_sel = 4'd5; w = 16'hACE1;
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R5 prbs word", tx_word, w);
            w = nx(w);
        end
        // R5: generator holds while another source is chosen.
        tx_sel = 4'd0; step(); step();
        tx_sel = 4'd5; step();
        chk("R5 prbs resume", tx_word, w);

        // R3/R4: source vector table.
        for (int i = 0; i < NV; i++) begin
            tx_sel = V_SEL[i]; user_word = V_USR[i]; custom_word = V_CUS[i]; rx_word = V_RX[i];
            step();
            chk("R3/R4 source vector", tx_word, V_EXP[i]);
        end

        // R2: transmitter disabled with a non-zero source.
        tx_en = 0; tx_sel = 4'd3; step();
        chk("R2 tx disabled", tx_word, 0);
        tx_en = 1;

        // R8/R7/R6: received stream with one corruption and one zero word.
        tx_sel = 4'd5; rx_en = 1; cnt_clr = 1; step(); cnt_clr = 0;
        w = 16'h1234; rx_word = w; step();
        for (int i = 1; i < 6; i++) begin
            w = nx(w);
            rx_word = (i == 3) ? (w ^ 16'h0001) : w;
            step();
            if (i == 2) begin
                rx_word = 16'h0000; step();
                chk("R6 raw zero word", rx_raw, 0);
            end
        end
        chk("R8 one error", err_count, 1);
        chk("R7 nonzero count", data_count, 6);
        chk("R6 last nonzero", rx_last_nz, w);

        // R6/R7: receiver disabled ignores the word.
        rx_en = 0; rx_word = 16'h5555; step();
        chk("R7 disabled no count", data_count, 6);
        chk("R6 raw holds", rx_raw, w);
        chk("R8 disabled no error", err_count, 1);

        // R9: clear with a concurrent countable word.
        rx_en = 1; cnt_clr = 1; rx_word = 16'h7777; step(); cnt_clr = 0;
        chk("R9 data cleared", data_count, 0);
        chk("R9 err cleared", err_count, 0);

        // R11: fifteen alignment words, a break, then a full run.
        tx_sel = 4'd0; train_en = 1; rx_word = 16'h00FF;
        repeat (15) step();
        chk("R11 fifteen short", train_ok, 0);
        rx_word = 16'h0001; step();
        rx_word = 16'h00FF; repeat (15) step();
        chk("R11 run restarted", train_ok, 0);
        rx_en = 0; rx_word = 16'h0002; step();
        rx_en = 1; rx_word = 16'h00FF; step();
        chk("R11 sixteenth word", train_ok, 1);
        rx_word = 16'h0003; step();
        chk("R11 flag held", train_ok, 1);
        train_en = 0; step();
        chk("R11 flag dropped", train_ok, 0);

        // R10: saturation of a narrow counter.
        cnt_clr = 1; step(); cnt_clr = 0;
        tx_sel = 4'd1;
        for (int i = 0; i < 20; i++) begin
            rx_word = 16'h0100 + 16'(i); step();
        end
        chk("R10 data saturates", s_data, 15);
        chk("R7 wide data count", data_count, 20);
        tx_sel = 4'd5; w = 16'h0BAD; rx_word = w; step();
        e_err = 0;
        for (int i = 0; i < 18; i++) begin
            w = nx(w); rx_word = ~w;
            if (rx_word != 0) e_err++;
            step();
        end
        chk("R10 err saturates", s_err, 15);
        chk("R8 wide err count", err_count, 32'(e_err));

        // R1: reset in mid-run.
        rst_n = 0; step(); rst_n = 1;
        chk("R1 counts after reset", data_count, 0);
        chk("R1 tx after reset", tx_word, 0);

        finish_run();
    end

endmodule